// File: doc/BRIEF.md
# First-Hit Fine-Time Compressor

This block shrinks each stored event record before it leaves for the output link. A record carries a coarse timestamp and two banks of sampled comparator codes. The block locates the earliest sample cell in the first bank whose code is not zero, and takes that cell's position as the fine time. It then emits a shorter record with three parts: the timestamp, the fine time, and a fixed-length window of codes that starts at that cell. The window is aligned to the hit, not to the bank boundary, so it can run on into the second bank.

A record whose first bank holds no hit is consumed and discarded. The block takes one record at a time, with valid/ready handshakes on both sides. Build-time parameters set the code width (4 bits for 16 thresholds, 2 bits for 4 thresholds), the bank size and the window length. With the defaults, a 144-bit input record becomes an 84-bit output record. With 2-bit codes, an 80-bit input record becomes a 52-bit output record.

Top module: `fc_compressor`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The input timestamp sits in the top `TS_W` bits of `in_data`. Sample cell i (i = 0 .. 2*BANK_CELLS-1) sits at bits [i*CODE_W +: CODE_W], and cells below BANK_CELLS form the first bank. The output timestamp sits in the top `TS_W` bits of `out_data` and equals the input timestamp.
- R3: The fine time sits at bits [WIN*CODE_W +: FT_W] of `out_data`. It is the lowest cell index below BANK_CELLS whose code is nonzero. When several such cells are nonzero, the lowest index is chosen.
- R4: Output window code k sits at bits [k*CODE_W +: CODE_W] of `out_data` and equals input cell (fine time + k). The window crosses into the second bank where that applies. A position past the last cell reads as zero.
- R5: A record whose first-bank cells are all zero is accepted and produces no output. This holds even when second-bank cells are nonzero.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R7: `in_ready` is 0 whenever an output word is pending. A record offered during that time is not taken, and it is taken only after the pending word leaves.
- R8: A record with a hit, accepted at a clock edge, shows on `out_data` with `out_valid` 1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input record offered |
| in_ready | output | 1 | Block can take a record |
| in_data | input | TS_W+2*BANK_CELLS*CODE_W | Stored event record (144 by default) |
| out_valid | output | 1 | Compressed record pending |
| out_ready | input | 1 | Downstream takes the compressed record |
| out_data | output | TS_W+FT_W+WIN*CODE_W | Compressed record (84 by default) |

## Verification
The bench builds the block with 2-bit codes, 16-cell banks and a 16-cell window, which gives 80-bit inputs and 52-bit outputs. This small code width lets the bench sweep every hit position from 0 to 15 with many random fills. The sweep covers windows that reach deep into the second bank and records with many nonzero cells, which tests the priority choice. Drop cases with an empty first bank and a busy second bank are included. A stalled output with a competing offer tests the handshake ordering.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int TS_W_DEF   = 16;
    localparam int CODE_W_DEF = 4;
    localparam int CELLS_DEF  = 16;
    localparam int WIN_DEF    = 16;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_e;

    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fc_first_hit.sv
module fc_first_hit #(
    parameter int CODE_W = 4,
    parameter int N      = 16,
    parameter int IDX_W  = 4
) (
    input  logic [N*CODE_W-1:0] cells,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    logic [N-1:0] nz;

    generate
        for (genvar i = 0; i < N; i++) begin : g_nz
            assign nz[i] = |cells[i*CODE_W +: CODE_W];
        end
    endgenerate

    // Scan downward so the lowest nonzero cell is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (nz[i]) idx = IDX_W'(i);
        end
    end

    assign found = |nz;

endmodule

// File: rtl/fc_window_align.sv
module fc_window_align #(
    parameter int CODE_W = 4,
    parameter int NCELLS = 32,
    parameter int WIN    = 16,
    parameter int IDX_W  = 4
) (
    input  logic [NCELLS*CODE_W-1:0] cells,
    input  logic [IDX_W-1:0]         start,
    output logic [WIN*CODE_W-1:0]    win
);
    localparam int EXT_W = (NCELLS + WIN) * CODE_W;
    localparam int SH_W  = $clog2(EXT_W + 1);

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] shifted;
    logic [SH_W-1:0]  shamt;

    // Zero padding above the last cell gives zero fill past the end.
    assign ext     = {{(WIN*CODE_W){1'b0}}, cells};
    assign shamt   = SH_W'(start) * SH_W'(CODE_W);
    assign shifted = ext >> shamt;
    assign win     = shifted[WIN*CODE_W-1:0];

endmodule

// File: rtl/fc_out_hold.sv
module fc_out_hold
    import fc_pkg::*;
#(
    parameter int W = 84
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         can_accept
);
    hold_e        st;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= HOLD_EMPTY;
            data_q <= '0;
        end else begin
            case (st)
                HOLD_EMPTY: if (load) begin
                    st     <= HOLD_FULL;
                    data_q <= din;
                end
                HOLD_FULL: if (out_ready) st <= HOLD_EMPTY;
                default:   st <= HOLD_EMPTY;
            endcase
        end
    end

    assign out_valid  = (st == HOLD_FULL);
    assign can_accept = (st == HOLD_EMPTY);
    assign out_data   = data_q;

endmodule

// File: rtl/fc_compressor.sv
module fc_compressor
    import fc_pkg::*;
#(
    parameter int TS_W       = TS_W_DEF,
    parameter int CODE_W     = CODE_W_DEF,
    parameter int BANK_CELLS = CELLS_DEF,
    parameter int WIN        = WIN_DEF,
    localparam int NCELLS    = 2 * BANK_CELLS,
    localparam int IN_W      = TS_W + NCELLS * CODE_W,
    localparam int FT_W      = idx_width(BANK_CELLS),
    localparam int OUT_W     = TS_W + FT_W + WIN * CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    logic [TS_W-1:0]          ts;
    logic [NCELLS*CODE_W-1:0] cells;
    logic                     hit;
    logic [FT_W-1:0]          ftime;
    logic [WIN*CODE_W-1:0]    win;
    logic                     take;

    assign ts    = in_data[IN_W-1 -: TS_W];
    assign cells = in_data[NCELLS*CODE_W-1:0];

    fc_first_hit #(
        .CODE_W (CODE_W),
        .N      (BANK_CELLS),
        .IDX_W  (FT_W)
    ) u_hit (
        .cells (cells[BANK_CELLS*CODE_W-1:0]),
        .found (hit),
        .idx   (ftime)
    );

    fc_window_align #(
        .CODE_W (CODE_W),
        .NCELLS (NCELLS),
        .WIN    (WIN),
        .IDX_W  (FT_W)
    ) u_win (
        .cells (cells),
        .start (ftime),
        .win   (win)
    );

    assign take = in_valid && in_ready;

    fc_out_hold #(
        .W (OUT_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (take && hit),
        .din        ({ts, ftime, win}),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .can_accept (in_ready)
    );

endmodule

// File: rtl/fc_compressor_chk.sv
module fc_compressor_chk #(
    parameter int TS_W       = 16,
    parameter int CODE_W     = 4,
    parameter int BANK_CELLS = 16,
    parameter int IN_W       = 144,
    parameter int OUT_W      = 84
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    logic first_bank_busy;
    assign first_bank_busy = |in_data[BANK_CELLS*CODE_W-1:0];

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    a_r2_r8_ts_copy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && first_bank_busy) |=>
        (out_valid && out_data[OUT_W-1 -: TS_W] == $past(in_data[IN_W-1 -: TS_W])));

    a_r3_lead_nonzero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[CODE_W-1:0] != '0));

    a_r5_drop_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !first_bank_busy) |=> !out_valid);

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_busy_block: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

endmodule

bind fc_compressor fc_compressor_chk #(
    .TS_W       (TS_W),
    .CODE_W     (CODE_W),
    .BANK_CELLS (BANK_CELLS),
    .IN_W       (IN_W),
    .OUT_W      (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_fc_compressor.sv
`timescale 1ns/1ps
module sim_fc_compressor;
    localparam int TS_W  = 16;
    localparam int CW    = 2;
    localparam int BANK  = 16;
    localparam int WIN   = 16;
    localparam int NC    = 2 * BANK;
    localparam int FT_W  = 4;
    localparam int IN_W  = TS_W + NC * CW;
    localparam int OUT_W = TS_W + FT_W + WIN * CW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [OUT_W-1:0] out_data;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    fc_compressor #(
        .TS_W       (TS_W),
        .CODE_W     (CW),
        .BANK_CELLS (BANK),
        .WIN        (WIN)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [31:0] rnd_step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic next_rnd(output logic [31:0] v);
        seed = rnd_step(seed);
        v = seed;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record with first hit at cell f; fill cells after f at random.
    task automatic make_rec(input int f, output logic [IN_W-1:0] rec);
        logic [31:0] r;
        next_rnd(r);
        rec = '0;
        rec[IN_W-1 -: TS_W] = r[31:16];
        for (int i = 0; i < NC; i++) begin
            next_rnd(r);
            if (i == f)     rec[i*CW +: CW] = 2'(r[7:0] % 3 + 1);
            else if (i > f) rec[i*CW +: CW] = r[9:8];
        end
    endtask

    function automatic logic [OUT_W-1:0] expect_of(input logic [IN_W-1:0] rec, input int f);
        logic [OUT_W-1:0] o;
        o = '0;
        o[OUT_W-1 -: TS_W] = rec[IN_W-1 -: TS_W];
        o[WIN*CW +: FT_W]  = FT_W'(f);
        for (int k = 0; k < WIN; k++) begin
            if (f + k < NC) o[k*CW +: CW] = rec[(f+k)*CW +: CW];
        end
        return o;
    endfunction

    task automatic send_hit(input logic [IN_W-1:0] rec, input int f);
        logic [OUT_W-1:0] e;
        e = expect_of(rec, f);
        @(negedge clk);
        chk("R7 ready before offer", 64'(in_ready), 64'd1);
        in_data  = rec;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid after accept", 64'(out_valid), 64'd1);
        chk("R2 timestamp", 64'(out_data[OUT_W-1 -: TS_W]), 64'(e[OUT_W-1 -: TS_W]));
        chk("R3 fine time", 64'(out_data[WIN*CW +: FT_W]), 64'(f));
        chk("R4 window", 64'(out_data[WIN*CW-1:0]), 64'(e[WIN*CW-1:0]));
        chk("R7 busy while pending", 64'(in_ready), 64'd0);
        @(negedge clk);
        chk("R6 cleared once taken", 64'(out_valid), 64'd0);
    endtask

    task automatic send_drop(input logic [IN_W-1:0] rec);
        @(negedge clk);
        in_data  = rec;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 no output for empty bank", 64'(out_valid), 64'd0);
        chk("R5 ready after drop", 64'(in_ready), 64'd1);
        @(negedge clk);
        chk("R5 still no output", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [IN_W-1:0] rec;
        logic [IN_W-1:0] rec2;
        logic [OUT_W-1:0] e2;
        logic [31:0] r;

        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1 in_ready in reset", 64'(in_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1 in_ready after reset", 64'(in_ready), 64'd1);

        // Sweep every hit position with random fills (R2, R3, R4, R8).
        for (int f = 0; f < BANK; f++) begin
            for (int n = 0; n < 10; n++) begin
                make_rec(f, rec);
                send_hit(rec, f);
            end
        end

        // Dense record: every cell nonzero, lowest index must win (R3).
        rec = '0;
        rec[IN_W-1 -: TS_W] = 16'hBEEF;
        for (int i = 0; i < NC; i++) rec[i*CW +: CW] = 2'(i % 3 + 1);
        send_hit(rec, 0);

        // Hit in last first-bank cell: window ends at cell 30 (R4).
        rec = '0;
        rec[IN_W-1 -: TS_W] = 16'h0F0F;
        for (int i = 15; i < NC; i++) rec[i*CW +: CW] = 2'd3;
        send_hit(rec, 15);

        // All-empty and second-bank-only records are dropped (R5).
        send_drop('0);
        for (int n = 0; n < 8; n++) begin
            next_rnd(r);
            rec = '0;
            rec[IN_W-1 -: TS_W] = r[15:0];
            for (int i = BANK; i < NC; i++) begin
                next_rnd(r);
                rec[i*CW +: CW] = r[5:4];
            end
            rec[(BANK + n)*CW +: CW] = 2'd2;
            send_drop(rec);
        end

        // Stall: output held, competing offer waits (R6, R7).
        make_rec(5, rec);
        make_rec(9, rec2);
        e2 = expect_of(rec2, 9);
        @(negedge clk);
        out_ready = 1'b0;
        in_data   = rec;
        in_valid  = 1'b1;
        @(negedge clk);
        in_data = rec2;
        chk("R8 stalled word present", 64'(out_valid), 64'd1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R6 valid held", 64'(out_valid), 64'd1);
            chk("R6 data held", 64'(out_data[OUT_W-1 -: TS_W]), 64'(rec[IN_W-1 -: TS_W]));
            chk("R6 fine time held", 64'(out_data[WIN*CW +: FT_W]), 64'd5);
            chk("R7 not ready while stalled", 64'(in_ready), 64'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R7 offer not taken during stall", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 offer taken after release", 64'(out_valid), 64'd1);
        chk("R7 second record data", 64'(out_data[OUT_W-1:32]), 64'(e2[OUT_W-1:32]));
        chk("R4 second record window", 64'(out_data[31:0]), 64'(e2[31:0]));
        @(negedge clk);
        chk("R6 second word cleared", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule